// File: doc/BRIEF.md
# Slave SMBus Register-Access Command Decoder

This block sits behind an SMBus slave front end that has already matched the device address. The front end hands it framed bytes: a strobe when a transaction begins, each received byte in turn, and a strobe when the transaction ends. The first byte of every transaction is a command code. It carries two sequence flags, START and END, and a size code. The remaining bytes are payload. The decoder gathers payload fields across one or more transactions until one of them closes the sequence. It then issues a single internal register request: a 32-bit write with byte enables, or a read.

Read results are returned through a response byte stream that the front end pulls one byte at a time. The stream gives a byte count, then a status byte, then the data, least significant byte first. The status byte flags "not ready" while an issued read has not yet been answered, so the master polls until the flag clears. Sequences that close without having been opened, or that close with too few fields, are dropped and raise an error flag in the status.

Top module: `smb_regcmd_dec`

## Requirements
- R1: After reset no register request is issued, and the response stream reads count 0x05, status 0x01 and all-zero data.
- R2: Command code layout: bit 1 is START, bit 0 is END, and bits 3:2 are the size code (00 byte, 01 word, 10 block). In a block transaction the first payload byte is a count and is not taken as a field. Bits 7:4 are ignored.
- R3: Fields are taken in this order: CMD, ADDRL, ADDRU, then DATA0..DATA3 with DATA0 as the least significant byte. The register address is {ADDRU[5:0], ADDRL}, and ADDRU[7:6] is ignored.
- R4: In the CMD field, bit 0 selects the operation (1 read, 0 write) and bits 5:2 are the byte enables for DATA0..DATA3. Bits 7:6 are ignored.
- R5: A write sequence that closes with at least 7 fields gives exactly one reg_req pulse in the cycle after the closing stop strobe, with reg_we=1 and the address, enables and data taken from the fields. Fields beyond the seventh are ignored.
- R6: A read sequence that closes with at least 3 fields gives one reg_req pulse with reg_we=0 and reg_be=0. The status "not ready" bit then stays set until reg_rvalid arrives, and reg_rdata is captured at that point for read-back.
- R7: Fields gather across transactions of any size code. A sequence opened by START may be completed by later byte or word transactions.
- R8: A command code with START discards any partly gathered sequence and clears the error flag.
- R9: A transaction with END and payload is discarded and sets the error flag in either of two cases: no sequence is open, or the sequence has too few fields for its operation. In both cases no request is issued.
- R10: The response stream gives the count 0x05, then the status byte {err, not_ready, 5'b0, 1'b1}, then the four latched data bytes, then 0x00. It restarts at each transaction start and advances on rsp_ack. A transaction carrying only a command code without START leaves the gathered fields untouched.
- R11: A transaction whose command code has END=0 never issues a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | Pulse before the first byte of a transaction |
| frm_stop | input | 1 | Pulse after the last byte of a transaction |
| byte_vld | input | 1 | A received byte is present |
| byte_dat | input | 8 | Received byte |
| rsp_ack | input | 1 | Master consumed the current response byte |
| rsp_byte | output | 8 | Current response byte |
| reg_req | output | 1 | One-cycle register access request |
| reg_we | output | 1 | Request is a write |
| reg_addr | output | 14 | Doubleword register address |
| reg_be | output | 4 | Write byte enables |
| reg_wdata | output | 32 | Write data |
| reg_rvalid | input | 1 | Read data returned |
| reg_rdata | input | 32 | Returned read data |

## Verification
Writes are tried with every byte-enable pattern. Across that sweep the addresses vary and the ignored bits of ADDRU and CMD are set, which separates correct field placement from shifted or masked fields. Reads are issued both as one block transaction and as word/byte pieces. The status is polled before and after the data returns, which exposes a ready flag that clears too early or data that is not latched. Orphan END, short sequences, restart by START, over-long payloads and a read-back placed mid-sequence each distinguish a decoder that tracks sequence state from one that merely counts bytes.

// File: rtl/smb_cmd_pkg.sv
package smb_cmd_pkg;

  localparam int REG_ADDR_W = 14;
  localparam int CC_END_BIT   = 0;
  localparam int CC_START_BIT = 1;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_BLOCK = 2'd2,
    SZ_RSVD  = 2'd3
  } size_e;

  function automatic logic cc_is_block(input logic [7:0] cc);
    return cc[3:2] == SZ_BLOCK;
  endfunction

  function automatic logic [REG_ADDR_W-1:0] join_addr(input logic [7:0] lo,
                                                      input logic [7:0] hi);
    return {hi[5:0], lo};
  endfunction

  function automatic logic [7:0] status_byte(input logic nrdy, input logic err);
    return {err, nrdy, 5'b00000, 1'b1};
  endfunction

endpackage

// File: rtl/smb_frame_trk.sv
module smb_frame_trk
  import smb_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_start,
  input  logic       frm_stop,
  input  logic       byte_vld,
  input  logic [7:0] byte_dat,
  output logic       ev_open,
  output logic       ev_close,
  output logic       push_vld,
  output logic [7:0] push_dat
);

  logic in_frm, at_cc, skip_cnt, cc_end, has_pay;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frm   <= 1'b0;
      at_cc    <= 1'b0;
      skip_cnt <= 1'b0;
      cc_end   <= 1'b0;
      has_pay  <= 1'b0;
    end else if (frm_start) begin
      in_frm   <= 1'b1;
      at_cc    <= 1'b1;
      skip_cnt <= 1'b0;
      cc_end   <= 1'b0;
      has_pay  <= 1'b0;
    end else if (frm_stop) begin
      in_frm   <= 1'b0;
      at_cc    <= 1'b0;
      skip_cnt <= 1'b0;
      cc_end   <= 1'b0;
      has_pay  <= 1'b0;
    end else if (byte_vld && in_frm) begin
      if (at_cc) begin
        at_cc    <= 1'b0;
        cc_end   <= byte_dat[CC_END_BIT];
        skip_cnt <= cc_is_block(byte_dat);
      end else begin
        skip_cnt <= 1'b0;
        has_pay  <= 1'b1;
      end
    end
  end

  assign ev_open  = in_frm && byte_vld && at_cc && byte_dat[CC_START_BIT] && !frm_start;
  assign push_vld = in_frm && byte_vld && !at_cc && !skip_cnt && !frm_start && !frm_stop;
  assign push_dat = byte_dat;
  assign ev_close = frm_stop && cc_end && has_pay;

endmodule

// File: rtl/smb_field_acc.sv
module smb_field_acc #(
  parameter int FLD_N = 7,
  parameter int CNT_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ev_open,
  input  logic                        ev_close,
  input  logic                        push_vld,
  input  logic [7:0]                  push_dat,
  output logic                        active,
  output logic [CNT_W-1:0]            cnt,
  output logic [FLD_N-1:0][7:0]       flds
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FLD_N);

  logic room;
  assign room = cnt < CNT_MAX;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      flds   <= '0;
    end else if (ev_open) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (ev_close) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (push_vld && active && room) begin
      flds[cnt] <= push_dat;
      cnt       <= cnt + 1'b1;
    end
  end

  // R5: the field count never runs past the field store
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX);

  // R8: START empties the store and opens a sequence
  p_open_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_open |=> (cnt == '0) && active);

endmodule

// File: rtl/smb_reg_issue.sv
module smb_reg_issue
  import smb_cmd_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int FLD_N      = 7,
  parameter int CNT_W      = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ev_open,
  input  logic                         ev_close,
  input  logic                         active,
  input  logic [CNT_W-1:0]             cnt,
  input  logic [FLD_N-1:0][7:0]        flds,
  input  logic                         reg_rvalid,
  input  logic [8*DATA_BYTES-1:0]      reg_rdata,
  output logic                         reg_req,
  output logic                         reg_we,
  output logic [REG_ADDR_W-1:0]        reg_addr,
  output logic [DATA_BYTES-1:0]        reg_be,
  output logic [8*DATA_BYTES-1:0]      reg_wdata,
  output logic                         rd_pend,
  output logic                         err,
  output logic [8*DATA_BYTES-1:0]      rd_data
);

  localparam logic [CNT_W-1:0] RD_NEED = CNT_W'(3);
  localparam logic [CNT_W-1:0] WR_NEED = CNT_W'(FLD_N);

  logic [7:0] cmd;
  logic       is_rd, go_rd, go_wr, bad_close;
  logic       unused_bits;

  assign cmd       = flds[0];
  assign is_rd     = cmd[0];
  assign go_rd     = ev_close && active && is_rd && (cnt >= RD_NEED);
  assign go_wr     = ev_close && active && !is_rd && (cnt >= WR_NEED);
  assign bad_close = ev_close && !(go_rd || go_wr);
  assign unused_bits = ^{cmd[7:6], cmd[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_req   <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_be    <= '0;
      reg_wdata <= '0;
    end else begin
      reg_req <= go_rd || go_wr;
      if (go_rd || go_wr) begin
        reg_we    <= go_wr;
        reg_addr  <= join_addr(flds[1], flds[2]);
        reg_be    <= go_wr ? cmd[2 +: DATA_BYTES] : '0;
        reg_wdata <= go_wr ? flds[FLD_N-1:3] : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      err     <= 1'b0;
      rd_data <= '0;
    end else begin
      if (ev_open)        err <= 1'b0;
      else if (bad_close) err <= 1'b1;
      if (go_rd)           rd_pend <= 1'b1;
      else if (reg_rvalid) rd_pend <= 1'b0;
      if (reg_rvalid && rd_pend) rd_data <= reg_rdata;
    end
  end

  // R5: a request lasts exactly one cycle
  p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> !reg_req);

  // R6: an issued read shows as busy together with its request
  p_read_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go_rd |=> rd_pend && reg_req && !reg_we && (reg_be == '0));

  // R6: returned data ends the busy state
  p_rvalid_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && reg_rvalid && !go_rd) |=> !rd_pend);

  // R9: a close with no open sequence raises the error flag and no request
  p_orphan_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_close && !active) |=> err && !reg_req);

endmodule

// File: rtl/smb_rsp_mux.sv
module smb_rsp_mux
  import smb_cmd_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int IDX_W      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frm_start,
  input  logic                    rsp_ack,
  input  logic                    rd_pend,
  input  logic                    err,
  input  logic [8*DATA_BYTES-1:0] rd_data,
  output logic [7:0]              rsp_byte
);

  localparam logic [IDX_W-1:0] IDX_LAST = '1;

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n)                          idx <= '0;
    else if (frm_start)                  idx <= '0;
    else if (rsp_ack && idx != IDX_LAST) idx <= idx + 1'b1;
  end

  always_comb begin
    rsp_byte = 8'h00;
    if (idx == IDX_W'(0))      rsp_byte = 8'(1 + DATA_BYTES);
    else if (idx == IDX_W'(1)) rsp_byte = status_byte(rd_pend, err);
    else begin
      for (int k = 0; k < DATA_BYTES; k++)
        if (idx == IDX_W'(k + 2)) rsp_byte = rd_data[k*8 +: 8];
    end
  end

  // R10: every transaction restarts the response stream
  p_idx_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> (idx == '0));

endmodule

// File: rtl/smb_regcmd_dec.sv
module smb_regcmd_dec
  import smb_cmd_pkg::*;
#(
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frm_start,
  input  logic                    frm_stop,
  input  logic                    byte_vld,
  input  logic [7:0]              byte_dat,
  input  logic                    rsp_ack,
  output logic [7:0]              rsp_byte,
  output logic                    reg_req,
  output logic                    reg_we,
  output logic [REG_ADDR_W-1:0]   reg_addr,
  output logic [DATA_BYTES-1:0]   reg_be,
  output logic [8*DATA_BYTES-1:0] reg_wdata,
  input  logic                    reg_rvalid,
  input  logic [8*DATA_BYTES-1:0] reg_rdata
);

  localparam int FLD_N = 3 + DATA_BYTES;
  localparam int CNT_W = $clog2(FLD_N + 1);
  localparam int IDX_W = $clog2(DATA_BYTES + 3);

  logic                    ev_open, ev_close, push_vld, active, rd_pend, err;
  logic [7:0]              push_dat;
  logic [CNT_W-1:0]        cnt;
  logic [FLD_N-1:0][7:0]   flds;
  logic [8*DATA_BYTES-1:0] rd_data;

  smb_frame_trk i_trk (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_stop(frm_stop),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .ev_open(ev_open),
    .ev_close(ev_close), .push_vld(push_vld), .push_dat(push_dat)
  );

  smb_field_acc #(.FLD_N(FLD_N), .CNT_W(CNT_W)) i_acc (
    .clk(clk), .rst_n(rst_n), .ev_open(ev_open), .ev_close(ev_close),
    .push_vld(push_vld), .push_dat(push_dat), .active(active),
    .cnt(cnt), .flds(flds)
  );

  smb_reg_issue #(.DATA_BYTES(DATA_BYTES), .FLD_N(FLD_N), .CNT_W(CNT_W)) i_iss (
    .clk(clk), .rst_n(rst_n), .ev_open(ev_open), .ev_close(ev_close),
    .active(active), .cnt(cnt), .flds(flds), .reg_rvalid(reg_rvalid),
    .reg_rdata(reg_rdata), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .rd_pend(rd_pend), .err(err), .rd_data(rd_data)
  );

  smb_rsp_mux #(.DATA_BYTES(DATA_BYTES), .IDX_W(IDX_W)) i_rsp (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .rsp_ack(rsp_ack),
    .rd_pend(rd_pend), .err(err), .rd_data(rd_data), .rsp_byte(rsp_byte)
  );

endmodule

// File: tb/test_smb_regcmd_dec.sv
module test_smb_regcmd_dec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_start = 1'b0, frm_stop = 1'b0, byte_vld = 1'b0, rsp_ack = 1'b0;
  logic [7:0]  byte_dat = 8'h00;
  logic [7:0]  rsp_byte;
  logic        reg_req, reg_we, reg_rvalid = 1'b0;
  logic [13:0] reg_addr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata, reg_rdata = 32'h0;

  int total = 0, bad = 0, nreq = 0, cyc = 0;
  bit done = 0;
  logic        c_we;
  logic [13:0] c_addr;
  logic [3:0]  c_be;
  logic [31:0] c_wd;
  logic [7:0]  q [0:15];
  int          qn;
  logic [7:0]  rb [0:7];
  logic [31:0] last_rd = 32'h0;

  always #10 clk = ~clk;

  smb_regcmd_dec i_smb_regcmd_dec (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_stop(frm_stop),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .rsp_ack(rsp_ack),
    .rsp_byte(rsp_byte), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata)
  );

  always @(negedge clk) if (rst_n && reg_req) begin
    nreq++; c_we = reg_we; c_addr = reg_addr; c_be = reg_be; c_wd = reg_wdata;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] rd_pattern(input logic [13:0] a);
    return {a[7:0] ^ 8'hA5, 2'b00, a, ~a[7:0]};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] cc);
    @(negedge clk) frm_start = 1'b1;
    @(negedge clk) frm_start = 1'b0; byte_vld = 1'b1; byte_dat = cc;
    for (int i = 0; i < qn; i++) begin
      @(negedge clk) byte_dat = q[i];
    end
    @(negedge clk) byte_vld = 1'b0; frm_stop = 1'b1;
    @(negedge clk) frm_stop = 1'b0;
    @(negedge clk);
  endtask

  task automatic readback();
    @(negedge clk) frm_start = 1'b1;
    @(negedge clk) frm_start = 1'b0; byte_vld = 1'b1; byte_dat = 8'h08;
    @(negedge clk) byte_vld = 1'b0;
    for (int k = 0; k < 8; k++) begin
      rb[k] = rsp_byte; rsp_ack = 1'b1;
      @(negedge clk);
    end
    rsp_ack = 1'b0; frm_stop = 1'b1;
    @(negedge clk) frm_stop = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_rb(input string rq, input logic nrdy, input logic err,
                        input logic [31:0] d);
    readback();
    chk({rq, " R10 count"}, {24'h0, rb[0]}, 32'h5);
    chk({rq, " R10 status"}, {24'h0, rb[1]}, {24'h0, err, nrdy, 6'b000001});
    for (int k = 0; k < 4; k++)
      chk({rq, " R10 data"}, {24'h0, rb[2+k]}, {24'h0, d[k*8 +: 8]});
    chk({rq, " R10 tail"}, {24'h0, rb[6]}, 32'h0);
    chk({rq, " R10 tail"}, {24'h0, rb[7]}, 32'h0);
  endtask

  task automatic answer(input logic [13:0] a);
    repeat (3) @(negedge clk);
    reg_rvalid = 1'b1; reg_rdata = rd_pattern(a);
    @(negedge clk) reg_rvalid = 1'b0; reg_rdata = 32'h0;
    last_rd = rd_pattern(a);
    @(negedge clk);
  endtask

  initial begin
    int pre;
    logic [13:0] a;
    logic [31:0] wd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: quiet after reset
    chk("R1 no request", nreq, 0);
    chk_rb("R1 reset", 1'b0, 1'b0, 32'h0);

    // R2 R3 R4 R5: write sweep over every byte-enable pattern
    for (int be = 0; be < 16; be++) begin
      a  = 14'((be * 977 + 13) & 14'h3fff);
      wd = 32'h1234_5678 ^ (be * 32'h0101_0101) ^ {18'h0, a};
      q[0] = 8'd7;
      q[1] = {2'(be), 4'(be), 2'b00};
      q[2] = a[7:0];
      q[3] = {2'(be + 1), a[13:8]};
      q[4] = wd[7:0]; q[5] = wd[15:8]; q[6] = wd[23:16]; q[7] = wd[31:24];
      qn = 8; pre = nreq;
      send(8'h0B | (8'(be) << 4));
      chk("R5 one request", nreq - pre, 1);
      chk("R5 write flag", {31'h0, c_we}, 32'h1);
      chk("R3 address", {18'h0, c_addr}, {18'h0, a});
      chk("R4 enables", {28'h0, c_be}, be);
      chk("R3 write data", c_wd, wd);
    end

    // R6: read in one block transaction, polled before and after data
    a = 14'h2A5C;
    q[0] = 8'd3; q[1] = 8'hC1; q[2] = a[7:0]; q[3] = {2'b10, a[13:8]};
    qn = 4; pre = nreq;
    send(8'h0B);
    chk("R6 one request", nreq - pre, 1);
    chk("R6 read flag", {31'h0, c_we}, 32'h0);
    chk("R6 read enables", {28'h0, c_be}, 32'h0);
    chk("R6 read address", {18'h0, c_addr}, {18'h0, a});
    chk_rb("R6 busy", 1'b1, 1'b0, 32'h0);
    answer(a);
    chk_rb("R6 ready", 1'b0, 1'b0, last_rd);

    // R7 R11: read split as START word then END byte
    a = 14'h0133;
    q[0] = 8'h01; q[1] = a[7:0]; qn = 2; pre = nreq;
    send(8'h06);
    chk("R11 no request without END", nreq - pre, 0);
    q[0] = {2'b00, a[13:8]}; qn = 1;
    send(8'h01);
    chk("R7 split read request", nreq - pre, 1);
    chk("R7 split read address", {18'h0, c_addr}, {18'h0, a});
    answer(a);

    // R7 R11: write split over four transactions
    a = 14'h3E01; wd = 32'hCAFE_F00D;
    pre = nreq;
    q[0] = 8'h3C; q[1] = a[7:0]; qn = 2; send(8'h06);
    q[0] = {2'b00, a[13:8]}; q[1] = wd[7:0]; send(8'h04);
    q[0] = wd[15:8]; q[1] = wd[23:16]; send(8'h04);
    chk("R11 no request mid-sequence", nreq - pre, 0);
    q[0] = wd[31:24]; qn = 1; send(8'h01);
    chk("R7 split write request", nreq - pre, 1);
    chk("R7 split write flag", {31'h0, c_we}, 32'h1);
    chk("R7 split write address", {18'h0, c_addr}, {18'h0, a});
    chk("R7 split write enables", {28'h0, c_be}, 32'hF);
    chk("R7 split write data", c_wd, wd);

    // R8: restart discards a partial write
    pre = nreq;
    q[0] = 8'h00; q[1] = 8'hAA; qn = 2; send(8'h06);
    q[0] = 8'd3; q[1] = 8'h01; q[2] = 8'h21; q[3] = 8'h03; qn = 4; send(8'h0B);
    chk("R8 single request", nreq - pre, 1);
    chk("R8 restarted read", {18'h0, c_we, c_addr}, {18'h0, 1'b0, 14'h0321});
    answer(14'h0321);

    // R5: extra fields ignored
    pre = nreq;
    q[0] = 8'd8; q[1] = 8'h3C; q[2] = 8'h10; q[3] = 8'h02;
    q[4] = 8'h11; q[5] = 8'h22; q[6] = 8'h33; q[7] = 8'h44; q[8] = 8'hEE;
    qn = 9; send(8'h0B);
    chk("R5 over-long request", nreq - pre, 1);
    chk("R5 over-long data", c_wd, 32'h4433_2211);

    // R9: orphan END
    pre = nreq;
    q[0] = 8'h55; qn = 1; send(8'h01);
    chk("R9 orphan no request", nreq - pre, 0);
    chk_rb("R9 orphan", 1'b0, 1'b1, last_rd);

    // R9: short sequence
    q[0] = 8'h00; q[1] = 8'h12; qn = 2; send(8'h07);
    chk("R9 short no request", nreq - pre, 0);
    chk_rb("R9 short", 1'b0, 1'b1, last_rd);

    // R8 R10: START clears error, read-back mid-sequence keeps fields
    q[0] = 8'h01; q[1] = 8'h34; qn = 2; send(8'h06);
    chk_rb("R8 error cleared", 1'b0, 1'b0, last_rd);
    q[0] = 8'h05; qn = 1; send(8'h01);
    chk("R10 fields kept across read-back", nreq - pre, 1);
    chk("R10 kept address", {18'h0, c_addr}, 32'h0534);
    answer(14'h0534);
    chk_rb("R6 final", 1'b0, 1'b0, rd_pattern(14'h0534));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule